// File: doc/BRIEF.md
# Match-Triggered Watchdog Timer

This block is a memory-mapped watchdog built around a free-running up-counter and one compare register. Software loads a timeout into the compare register and enables counting. When the running counter equals the compare value, the block can take several actions, each chosen by its own control bit. It can raise an interrupt, change the level of an external match pin, start a timed reset pulse on an internal reset line, an external reset line or both, and restart or halt the counter.

The counter can be held by a debug-halt input when software allows it. Both reset lines can also be forced high directly by software. A sticky status bit records that a match-triggered reset pulse has been issued. Only the block's own power-on reset clears this bit, so firmware can read it after a restart to learn whether the watchdog caused that restart.

With the default 13 MHz count clock, the compare register resets to a 19 s timeout (247,000,000 counts). Timeouts up to 60 s fit in the 32-bit compare register. The register bus is a single-cycle 32-bit interface addressed by word index.

Top module: `mwdt_top`

## Requirements
- R1: After reset the counter reads 0, the control word reads 0, the compare register (word 4) reads 247,000,000, the pulse-width register (word 6) reads 0xFFFF, the status word (word 7) reads 0, and all four outputs are low.
- R2: While control bit 0 (word 1) is 1 and the counter is not halted, the counter (word 2) increases by one per clock. Writing 0 to the control word stops it, and it holds its value.
- R3: Writing 1 to control bit 1 clears the counter to zero at that clock edge, with priority over counting. The bit always reads back as 0.
- R4: With control bit 2 set, a high dbg_halt_i holds the counter. With bit 2 clear, dbg_halt_i has no effect.
- R5: A match happens when the counter is running and equals the compare value. A match sets bit 0 of word 0, and writing 1 to that bit clears it. A clear written in the same cycle as a match leaves the bit set. irq_o is that bit ANDed with bit 0 of the match-action word (word 3).
- R6: With match-action bit 1 set, a match restarts the counter from zero and counting continues. With bit 2 set, a match zeroes the counter and clears control bit 0.
- R7: Match-action bits 3 and 4 select rst_int_o and rst_ext_o. A match with either bit set drives the selected lines high for exactly (word 6 value + 6) clocks, starting on the clock after the match cycle. The lines then fall by themselves.
- R8: Match-action bits 5 and 6 hold rst_int_o and rst_ext_o high, respectively, for as long as they are set.
- R9: Bits [5:4] of word 5 pick the pin action on a match: 0 keeps the level, 1 drives it low, 2 drives it high, 3 inverts it. Bit 0 of word 5 is the pin level, which software can read and write, and it drives match_pin_o.
- R10: Bit 0 of word 7 is set when a match-triggered reset pulse starts. It stays set until rst_n is asserted, and bus writes do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count and register clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high together with bus_sel |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dbg_halt_i | input | 1 | Debugger halt request |
| irq_o | output | 1 | Match interrupt |
| match_pin_o | output | 1 | External match pin |
| rst_int_o | output | 1 | Internal reset request |
| rst_ext_o | output | 1 | External reset request |

## Verification
Two collisions matter here. In the first, a software write-1-to-clear of the interrupt flag lands on the same clock edge as a match that sets the flag. The bench runs the counter to exactly one edge before the compare value and then issues the clear on the matching edge. Reading the flag back afterwards must show it still set. In the second, a stop-on-match coincides with software activity on the same counter, and this is judged by reading the control word and counter after the match edge. A bound property also checks that a match with stop selected always leaves the counter at zero and disabled.

// File: rtl/mwdt_pkg.sv
package mwdt_pkg;

  // Word indices of the register window
  typedef enum logic [2:0] {
    RI_FLAG  = 3'd0,
    RI_CTRL  = 3'd1,
    RI_COUNT = 3'd2,
    RI_ACT   = 3'd3,
    RI_CMP   = 3'd4,
    RI_PIN   = 3'd5,
    RI_WIDTH = 3'd6,
    RI_STAT  = 3'd7
  } reg_idx_e;

  // Pin action on a match
  typedef enum logic [1:0] {
    PA_KEEP   = 2'd0,
    PA_LOW    = 2'd1,
    PA_HIGH   = 2'd2,
    PA_INVERT = 2'd3
  } pin_act_e;

  // Match-action word, bit 0 at the bottom
  typedef struct packed {
    logic frc_ext;   // bit 6
    logic frc_int;   // bit 5
    logic sel_ext;   // bit 4
    logic sel_int;   // bit 3
    logic halt;      // bit 2
    logic restart;   // bit 1
    logic irq_en;    // bit 0
  } act_t;

endpackage

// File: rtl/mwdt_counter.sv
module mwdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    hit   = run && (cnt_q == cmp_val);
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (run)
      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/mwdt_pulse.sv
module mwdt_pulse #(
  parameter int PW_W  = 16,
  parameter int EXTRA = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            sel_int,
  input  logic            sel_ext,
  input  logic [PW_W-1:0] width,
  input  logic            frc_int,
  input  logic            frc_ext,
  output logic            rst_int_o,
  output logic            rst_ext_o
);

  localparam int LEN_W = PW_W + 1;

  logic [LEN_W-1:0] len_q, len_d;
  logic             int_q, int_d;
  logic             ext_q, ext_d;
  logic             active;

  always_comb begin
    len_d = len_q;
    int_d = int_q;
    ext_d = ext_q;
    if (fire) begin
      len_d = LEN_W'(width) + LEN_W'(EXTRA);
      int_d = sel_int;
      ext_d = sel_ext;
    end else if (len_q != '0) begin
      len_d = len_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      int_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      len_q <= len_d;
      int_q <= int_d;
      ext_q <= ext_d;
    end
  end

  assign active    = (len_q != '0);
  assign rst_int_o = (active && int_q) || frc_int;
  assign rst_ext_o = (active && ext_q) || frc_ext;

endmodule

// File: rtl/mwdt_regs.sv
module mwdt_regs
  import mwdt_pkg::*;
#(
  parameter int               CNT_W     = 32,
  parameter int               PW_W      = 16,
  parameter logic [CNT_W-1:0] CMP_RESET = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             hit,
  input  logic             fire,
  output logic             en,
  output logic             halt_en,
  output logic             clr_req,
  output act_t             act,
  output logic [CNT_W-1:0] cmp_val,
  output logic [PW_W-1:0]  width,
  output logic             pin,
  output logic             flag,
  output logic             stat
);

  localparam int ACT_W = $bits(act_t);

  logic             we;
  reg_idx_e         idx;

  logic             en_q, en_d;
  logic             hen_q, hen_d;
  act_t             act_q, act_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [PW_W-1:0]  wid_q, wid_d;
  logic             pin_q, pin_d;
  pin_act_e         pact_q, pact_d;
  logic             flag_q, flag_d;
  logic             stat_q, stat_d;

  assign we  = bus_sel && bus_wr;
  assign idx = reg_idx_e'(bus_addr);

  // next-state
  always_comb begin
    en_d   = en_q;
    hen_d  = hen_q;
    act_d  = act_q;
    cmp_d  = cmp_q;
    wid_d  = wid_q;
    pin_d  = pin_q;
    pact_d = pact_q;
    flag_d = flag_q;
    stat_d = stat_q;

    if (we) begin
      unique case (idx)
        RI_FLAG:  if (bus_wdata[0]) flag_d = 1'b0;
        RI_CTRL:  begin
                    en_d  = bus_wdata[0];
                    hen_d = bus_wdata[2];
                  end
        RI_ACT:   act_d  = act_t'(bus_wdata[ACT_W-1:0]);
        RI_CMP:   cmp_d  = bus_wdata[CNT_W-1:0];
        RI_PIN:   begin
                    pin_d  = bus_wdata[0];
                    pact_d = pin_act_e'(bus_wdata[5:4]);
                  end
        RI_WIDTH: wid_d  = bus_wdata[PW_W-1:0];
        default:  ;
      endcase
    end

    if (hit) begin
      flag_d = 1'b1;
      if (act_q.halt) en_d = 1'b0;
      unique case (pact_q)
        PA_LOW:    pin_d = 1'b0;
        PA_HIGH:   pin_d = 1'b1;
        PA_INVERT: pin_d = ~pin_q;
        default:   ;
      endcase
    end

    if (fire) stat_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      hen_q  <= 1'b0;
      act_q  <= '0;
      cmp_q  <= CMP_RESET;
      wid_q  <= '1;
      pin_q  <= 1'b0;
      pact_q <= PA_KEEP;
      flag_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      hen_q  <= hen_d;
      act_q  <= act_d;
      cmp_q  <= cmp_d;
      wid_q  <= wid_d;
      pin_q  <= pin_d;
      pact_q <= pact_d;
      flag_q <= flag_d;
      stat_q <= stat_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (idx)
      RI_FLAG:  bus_rdata[0]       = flag_q;
      RI_CTRL:  begin
                  bus_rdata[0] = en_q;
                  bus_rdata[2] = hen_q;
                end
      RI_COUNT: bus_rdata[CNT_W-1:0] = cnt;
      RI_ACT:   bus_rdata[ACT_W-1:0] = act_q;
      RI_CMP:   bus_rdata[CNT_W-1:0] = cmp_q;
      RI_PIN:   begin
                  bus_rdata[0]   = pin_q;
                  bus_rdata[5:4] = pact_q;
                end
      RI_WIDTH: bus_rdata[PW_W-1:0] = wid_q;
      RI_STAT:  bus_rdata[0]       = stat_q;
      default:  ;
    endcase
  end

  assign clr_req = we && (idx == RI_CTRL) && bus_wdata[1];
  assign en      = en_q;
  assign halt_en = hen_q;
  assign act     = act_q;
  assign cmp_val = cmp_q;
  assign width   = wid_q;
  assign pin     = pin_q;
  assign flag    = flag_q;
  assign stat    = stat_q;

endmodule

// File: rtl/mwdt_top.sv
module mwdt_top
  import mwdt_pkg::*;
#(
  parameter int CLK_HZ        = 13_000_000,
  parameter int DEF_TIMEOUT_S = 19,
  parameter int CNT_W         = 32,
  parameter int PW_W          = 16,
  parameter int PULSE_EXTRA   = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        dbg_halt_i,
  output logic        irq_o,
  output logic        match_pin_o,
  output logic        rst_int_o,
  output logic        rst_ext_o
);

  localparam logic [CNT_W-1:0] CMP_RESET =
    CNT_W'(64'(DEF_TIMEOUT_S) * 64'(CLK_HZ));

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  logic             en, halt_en, clr_req, run, clr, hit, fire, pin, flag, stat;
  act_t             act;
  logic [CNT_W-1:0] cmp_val, cnt;
  logic [PW_W-1:0]  width;

  assign run  = en && !(halt_en && dbg_halt_i);
  assign clr  = clr_req || (hit && (act.restart || act.halt));
  assign fire = hit && (act.sel_int || act.sel_ext);

  mwdt_regs #(
    .CNT_W     (CNT_W),
    .PW_W      (PW_W),
    .CMP_RESET (CMP_RESET)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_ns),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt       (cnt),
    .hit       (hit),
    .fire      (fire),
    .en        (en),
    .halt_en   (halt_en),
    .clr_req   (clr_req),
    .act       (act),
    .cmp_val   (cmp_val),
    .width     (width),
    .pin       (pin),
    .flag      (flag),
    .stat      (stat)
  );

  mwdt_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_ns),
    .run     (run),
    .clr     (clr),
    .cmp_val (cmp_val),
    .cnt     (cnt),
    .hit     (hit)
  );

  mwdt_pulse #(
    .PW_W  (PW_W),
    .EXTRA (PULSE_EXTRA)
  ) u_pulse (
    .clk       (clk),
    .rst_n     (rst_ns),
    .fire      (fire),
    .sel_int   (act.sel_int),
    .sel_ext   (act.sel_ext),
    .width     (width),
    .frc_int   (act.frc_int),
    .frc_ext   (act.frc_ext),
    .rst_int_o (rst_int_o),
    .rst_ext_o (rst_ext_o)
  );

  assign irq_o       = flag && act.irq_en;
  assign match_pin_o = pin;

endmodule

// File: rtl/mwdt_chk.sv
module mwdt_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_ns,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [CNT_W-1:0] cnt,
  input logic             run,
  input logic             clr,
  input logic             hit,
  input logic             en,
  input logic             flag,
  input logic             stat,
  input logic             halt_sel,
  input logic             int_sel,
  input logic             rst_int_o
);

  // R2: a stopped, uncleared counter keeps its value
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (!run && !clr) |=> $stable(cnt));

  // R3: software clear request zeroes the counter
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_sel && bus_wr && bus_addr == 3'd1 && bus_wdata[1]) |=> (cnt == '0));

  // R5: a match always leaves the flag set
  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_ns)
    hit |=> flag);

  // R6: stop-on-match leaves the counter disabled at zero
  a_r6_stop: assert property (@(posedge clk) disable iff (!rst_ns)
    (hit && halt_sel) |=> (!en && cnt == '0));

  // R7: an internal reset pulse starts right after a selected match
  a_r7_pulse_start: assert property (@(posedge clk) disable iff (!rst_ns)
    (hit && int_sel) |=> rst_int_o);

  // R10: the status bit never falls while out of reset
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_ns)
    stat |=> stat);

endmodule

bind mwdt_top mwdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .cnt       (cnt),
  .run       (run),
  .clr       (clr),
  .hit       (hit),
  .en        (en),
  .flag      (flag),
  .stat      (stat),
  .halt_sel  (act.halt),
  .int_sel   (act.sel_int),
  .rst_int_o (rst_int_o)
);

// File: tb/sim_mwdt_top.sv
module sim_mwdt_top;

  localparam int CLK_P = 10;

  localparam logic [2:0] A_FLAG = 3'd0, A_CTRL = 3'd1, A_CNT = 3'd2, A_ACT = 3'd3,
                         A_CMP = 3'd4, A_PIN = 3'd5, A_WID = 3'd6, A_STAT = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, dbg_halt_i;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o, match_pin_o, rst_int_o, rst_ext_o;

  always #(CLK_P/2) clk = ~clk;

  mwdt_top u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .dbg_halt_i  (dbg_halt_i),
    .irq_o       (irq_o),
    .match_pin_o (match_pin_o),
    .rst_int_o   (rst_int_o),
    .rst_ext_o   (rst_ext_o)
  );

  // scoreboard
  typedef struct {
    int          kind;   // 0: bus_rdata, 1: {pin, ext, int, irq}
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  event  smp_ev;
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  initial begin
    forever begin
      @(smp_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb.pop_front();
        act = (it.kind == 0) ? bus_rdata
                             : {28'd0, match_pin_o, rst_ext_o, rst_int_o, irq_o};
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push_item(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    #1;
    sb.push_back(it);
    ->smp_ev;
    #1;
  endtask

  task automatic chk_reg(logic [2:0] a, logic [31:0] exp, string tag);
    bus_addr = a;
    push_item(0, exp, tag);
  endtask

  task automatic chk_out(logic [3:0] exp, string tag);
    push_item(1, {28'd0, exp}, tag);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_sel   = 1'b1;
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0;
    bus_wr  = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // compare value 1: restart counting and pass one match
  task automatic run_to_match();
    wr(A_CTRL, 32'd2);
    wr(A_CTRL, 32'd1);
    idle(2);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; dbg_halt_i = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    chk_reg(A_CNT,  32'd0, "R1 counter");
    chk_reg(A_CTRL, 32'd0, "R1 control");
    chk_reg(A_CMP,  32'd247_000_000, "R1 compare default");
    chk_reg(A_WID,  32'h0000_FFFF, "R1 width default");
    chk_reg(A_STAT, 32'd0, "R1 status");
    chk_reg(A_FLAG, 32'd0, "R1 flag");
    chk_out(4'b0000, "R1 outputs");

    // R2 counting and stop
    wr(A_CMP, 32'd1000);
    wr(A_CTRL, 32'd1);
    idle(5);
    chk_reg(A_CNT, 32'd5, "R2 count up");
    wr(A_CTRL, 32'd0);
    idle(3);
    chk_reg(A_CNT, 32'd6, "R2 hold after stop");

    // R3 clear request
    wr(A_CTRL, 32'd2);
    chk_reg(A_CNT, 32'd0, "R3 cleared");
    chk_reg(A_CTRL, 32'd0, "R3 bit reads zero");

    // R4 debug halt
    dbg_halt_i = 1'b1;
    wr(A_CTRL, 32'd5);
    idle(4);
    chk_reg(A_CNT, 32'd0, "R4 halted");
    dbg_halt_i = 1'b0;
    idle(3);
    chk_reg(A_CNT, 32'd3, "R4 resumes");
    wr(A_CTRL, 32'd1);
    dbg_halt_i = 1'b1;
    idle(2);
    chk_reg(A_CNT, 32'd6, "R4 halt ignored when disabled");
    dbg_halt_i = 1'b0;

    // R5 match flag and interrupt
    wr(A_CTRL, 32'd2);
    wr(A_ACT, 32'd1);
    wr(A_CMP, 32'd10);
    wr(A_CTRL, 32'd1);
    idle(9);
    chk_reg(A_FLAG, 32'd0, "R5 flag before match");
    idle(1);
    chk_reg(A_CNT, 32'd10, "R5 counter at compare");
    idle(1);
    chk_reg(A_FLAG, 32'd1, "R5 flag after match");
    chk_out(4'b0001, "R5 irq");
    wr(A_FLAG, 32'd1);
    chk_reg(A_FLAG, 32'd0, "R5 flag cleared");
    chk_out(4'b0000, "R5 irq low");
    // collision: clear lands on the match edge
    wr(A_CTRL, 32'd2);
    wr(A_CMP, 32'd3);
    wr(A_CTRL, 32'd1);
    idle(3);
    wr(A_FLAG, 32'd1);
    chk_reg(A_FLAG, 32'd1, "R5 set beats clear");
    wr(A_CTRL, 32'd0);
    wr(A_FLAG, 32'd1);
    chk_reg(A_FLAG, 32'd0, "R5 flag cleared again");

    // R6 restart and stop on match
    wr(A_CTRL, 32'd2);
    wr(A_ACT, 32'd3);
    wr(A_CMP, 32'd4);
    wr(A_CTRL, 32'd1);
    idle(4);
    idle(1);
    idle(2);
    chk_reg(A_CNT, 32'd2, "R6 restarted count");
    chk_reg(A_CTRL, 32'd1, "R6 still enabled");
    wr(A_ACT, 32'd4);
    idle(1);
    idle(1);
    idle(2);
    chk_reg(A_CNT, 32'd0, "R6 stopped at zero");
    chk_reg(A_CTRL, 32'd0, "R6 enable cleared");
    wr(A_FLAG, 32'd1);

    // R7 reset pulse, internal line
    wr(A_WID, 32'd4);
    wr(A_ACT, 32'd8);
    wr(A_CMP, 32'd2);
    wr(A_CTRL, 32'd2);
    wr(A_CTRL, 32'd1);
    idle(2);
    idle(1);
    chk_out(4'b0010, "R7 internal pulse start");
    idle(9);
    chk_out(4'b0010, "R7 internal pulse last cycle");
    idle(1);
    chk_out(4'b0000, "R7 internal pulse ended");
    // R10 sticky status
    chk_reg(A_STAT, 32'd1, "R10 status set");
    wr(A_STAT, 32'd0);
    chk_reg(A_STAT, 32'd1, "R10 write ignored");
    // R7 external line
    wr(A_CTRL, 32'd2);
    wr(A_ACT, 32'd16);
    wr(A_CMP, 32'd1);
    wr(A_CTRL, 32'd1);
    idle(1);
    idle(1);
    chk_out(4'b0100, "R7 external pulse");
    wr(A_CTRL, 32'd0);
    idle(12);
    chk_out(4'b0000, "R7 external pulse ended");

    // R8 forced lines
    wr(A_ACT, 32'h20);
    chk_out(4'b0010, "R8 force internal");
    wr(A_ACT, 32'h40);
    chk_out(4'b0100, "R8 force external");
    wr(A_ACT, 32'h00);
    chk_out(4'b0000, "R8 release");

    // R9 pin actions
    wr(A_PIN, 32'h20);
    chk_reg(A_PIN, 32'h20, "R9 readback");
    run_to_match();
    chk_out(4'b1000, "R9 drive high");
    chk_reg(A_PIN, 32'h21, "R9 level readback");
    wr(A_PIN, 32'h31);
    run_to_match();
    chk_out(4'b0000, "R9 invert");
    wr(A_PIN, 32'h11);
    chk_out(4'b1000, "R9 software level");
    run_to_match();
    chk_out(4'b0000, "R9 drive low");
    wr(A_PIN, 32'h01);
    run_to_match();
    chk_out(4'b1000, "R9 keep");

    // R10 cleared only by power-on reset
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
    chk_reg(A_STAT, 32'd0, "R10 cleared by power-on reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule